// File: doc/BRIEF.md
# Extended 64-bit Integer ALU

This block is a purely combinational integer arithmetic and logic unit for a 64-bit execution pipeline. It takes two 64-bit source operands and a 7-bit operation code. It returns a 64-bit result and a one-bit branch-taken flag in the same cycle.

Besides the ordinary operations, it supports several less common ones:

- Shifts and rotates on 64-bit and 32-bit operands.
- Single-bit clear, set, toggle and extract.
- Word (32-bit) arithmetic with sign extension, plus word adds that keep only a bit, a byte or a halfword of the sum.
- Adds that use only bit 0 of the first source.
- Adds of the first source shifted right by 29 to 32 places.
- Scaled address adds, where the first source is shifted left by 1 to 4.
- Subtract, set-less-than, minimum and maximum.
- Bitwise logic, plus fused forms that reduce the logic result to its least significant bit or to a zero-extended low halfword.
- Branch condition evaluation.

The upper three code bits select an operation group and the lower four pick the operation within it. Every code that is not assigned returns a zero result.

Top module: `xalu`

## Requirements
- R1: Groups by code bits [6:4]: 000 shift/bit, 001 word, 010 add, 011 subtract/compare, 100 logic, 101 unused, 110 fused logic, 111 branch. Every unassigned code gives result 0 and taken 0; this includes all of group 101, codes 0x08 and 0x2E, and codes 0x47 to 0x4F. The taken flag is 0 for every code outside group 111.
- R2: 64-bit shifts use src2[5:0] as the amount. The codes are 0x01 left, 0x05 logical right, 0x07 arithmetic right, 0x09 rotate left and 0x0B rotate right. Code 0x00 shifts the zero-extended src1[31:0] left.
- R3: Single-bit ops take the bit index from src2[5:0]. Code 0x02 clears the bit, 0x03 sets it and 0x04 toggles it in src1. Code 0x06 returns that bit of src1 in bit 0, with all other bits 0.
- R4: Word ops sign-extend a 32-bit result from bit 31. They are 0x10 sum, 0x12 difference, 0x18 left shift, 0x19 logical right shift and 0x1A arithmetic right shift of src1[31:0]. 0x1C rotates src1[31:0] left and 0x1D rotates it right. All of these shift by src2[4:0].
- R5: Truncated word adds work on src1+src2. Code 0x14 keeps bit 0, 0x15 keeps bits [7:0], 0x16 zero-extends bits [15:0] and 0x17 sign-extends bits [15:0]. Code 0x11 sign-extends the low 32 bits of src1[0]+src2.
- R6: Add group: 0x21 gives src1+src2, 0x20 gives zero-extended src1[31:0] plus src2, and 0x22 gives src1[0]+src2. Codes 0x24, 0x25, 0x26 and 0x27 add src2 to src1 logically shifted right by 29, 30, 31 and 32 places.
- R7: Scaled adds add src2 to src1 shifted left by 1 (0x28, 0x29), 2 (0x2A, 0x2B), 3 (0x2C, 0x2D) or 4 (0x2F). The even codes 0x28, 0x2A and 0x2C first zero-extend src1[31:0].
- R8: Compare group:
  - 0x30 gives src1-src2.
  - 0x31 gives 1 when src1 is below src2 unsigned, and 0 otherwise.
  - 0x32 does the same for a signed comparison.
  - 0x34 and 0x35 give the unsigned maximum and minimum.
  - 0x36 and 0x37 give the signed maximum and minimum.
- R9: Logic group: 0x40 and, 0x41 src1 and-not src2, 0x42 or, 0x43 src1 or-not src2, 0x44 xor, 0x45 xnor. Code 0x46 maps each byte of src1 to 0xFF if it is nonzero and to 0x00 if it is zero.
- R10: Fused codes 0x60 to 0x67 apply the logic op whose code is 0x40 | {bits[3:1],0}. Bit 0 of the code picks the output: 0 returns only bit 0 of that logic result, and 1 returns its low 16 bits zero-extended.
- R11: Branch codes (group 111) give result 0. Bits [3:2] pick the test: 00 equal, 10 signed less-than, 11 unsigned less-than. Bit [1] inverts the test, bit [0] is ignored, and test 01 is never taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opc_i | input | 7 | Operation code: group in [6:4], operation in [3:0] |
| src1_i | input | XLEN | First source operand |
| src2_i | input | XLEN | Second source operand (shift amount or bit index in its low bits) |
| result_o | output | XLEN | Operation result |
| taken_o | output | 1 | Branch condition outcome, 0 outside the branch group |

## Verification
The hardest cases to reach from the ports are where two formulations of one operation disagree only at the edges:

- A rotate by zero, where the complementary shift equals the full width.
- Signed and unsigned comparisons of operands whose sign bits differ.
- Shifts where src2 carries set bits above the amount field.
- Truncating adds where a carry crosses the kept boundary.

The stimulus crosses all 128 operation codes, unassigned ones included, with every pair of a corner operand set. That set holds 0, all ones, the isolated 64-bit and 32-bit sign bits, the largest positive value, and the amounts 31, 32 and 63. Random operand pairs for every code follow.

// File: rtl/xalu_pkg.sv
package xalu_pkg;

   localparam int OPC_W = 7;

   typedef enum logic [2:0] {
      GRP_SHIFT  = 3'b000,
      GRP_WORD   = 3'b001,
      GRP_ADD    = 3'b010,
      GRP_SUB    = 3'b011,
      GRP_LOGIC  = 3'b100,
      GRP_SPARE  = 3'b101,
      GRP_FUSED  = 3'b110,
      GRP_BRANCH = 3'b111
   } grp_e;

   typedef enum logic [1:0] {
      CMP_EQ   = 2'b00,
      CMP_NONE = 2'b01,
      CMP_LT   = 2'b10,
      CMP_LTU  = 2'b11
   } cmp_e;

   // shift / single-bit group
   localparam logic [OPC_W-1:0] OP_SLLZW = 7'h00;
   localparam logic [OPC_W-1:0] OP_SLL   = 7'h01;
   localparam logic [OPC_W-1:0] OP_BCLR  = 7'h02;
   localparam logic [OPC_W-1:0] OP_BSET  = 7'h03;
   localparam logic [OPC_W-1:0] OP_BTOG  = 7'h04;
   localparam logic [OPC_W-1:0] OP_SRL   = 7'h05;
   localparam logic [OPC_W-1:0] OP_BGET  = 7'h06;
   localparam logic [OPC_W-1:0] OP_SRA   = 7'h07;
   localparam logic [OPC_W-1:0] OP_ROL   = 7'h09;
   localparam logic [OPC_W-1:0] OP_ROR   = 7'h0B;
   // word group
   localparam logic [OPC_W-1:0] OP_WADD  = 7'h10;
   localparam logic [OPC_W-1:0] OP_WODD  = 7'h11;
   localparam logic [OPC_W-1:0] OP_WSUB  = 7'h12;
   localparam logic [OPC_W-1:0] OP_WBIT  = 7'h14;
   localparam logic [OPC_W-1:0] OP_WBYTE = 7'h15;
   localparam logic [OPC_W-1:0] OP_WZH   = 7'h16;
   localparam logic [OPC_W-1:0] OP_WSH   = 7'h17;
   localparam logic [OPC_W-1:0] OP_WSLL  = 7'h18;
   localparam logic [OPC_W-1:0] OP_WSRL  = 7'h19;
   localparam logic [OPC_W-1:0] OP_WSRA  = 7'h1A;
   localparam logic [OPC_W-1:0] OP_WROL  = 7'h1C;
   localparam logic [OPC_W-1:0] OP_WROR  = 7'h1D;
   // add group
   localparam logic [OPC_W-1:0] OP_ADDZW = 7'h20;
   localparam logic [OPC_W-1:0] OP_ADD   = 7'h21;
   localparam logic [OPC_W-1:0] OP_ODD   = 7'h22;
   localparam logic [OPC_W-1:0] OP_SR0   = 7'h24;
   localparam logic [OPC_W-1:0] OP_SR1   = 7'h25;
   localparam logic [OPC_W-1:0] OP_SR2   = 7'h26;
   localparam logic [OPC_W-1:0] OP_SR3   = 7'h27;
   localparam logic [OPC_W-1:0] OP_SC1Z  = 7'h28;
   localparam logic [OPC_W-1:0] OP_SC1   = 7'h29;
   localparam logic [OPC_W-1:0] OP_SC2Z  = 7'h2A;
   localparam logic [OPC_W-1:0] OP_SC2   = 7'h2B;
   localparam logic [OPC_W-1:0] OP_SC3Z  = 7'h2C;
   localparam logic [OPC_W-1:0] OP_SC3   = 7'h2D;
   localparam logic [OPC_W-1:0] OP_SC4   = 7'h2F;
   // subtract / compare group
   localparam logic [OPC_W-1:0] OP_SUB   = 7'h30;
   localparam logic [OPC_W-1:0] OP_LTU   = 7'h31;
   localparam logic [OPC_W-1:0] OP_LT    = 7'h32;
   localparam logic [OPC_W-1:0] OP_MAXU  = 7'h34;
   localparam logic [OPC_W-1:0] OP_MINU  = 7'h35;
   localparam logic [OPC_W-1:0] OP_MAX   = 7'h36;
   localparam logic [OPC_W-1:0] OP_MIN   = 7'h37;

   // low nibble codes of the logic group
   localparam logic [3:0] LG_AND  = 4'h0;
   localparam logic [3:0] LG_ANDN = 4'h1;
   localparam logic [3:0] LG_OR   = 4'h2;
   localparam logic [3:0] LG_ORN  = 4'h3;
   localparam logic [3:0] LG_XOR  = 4'h4;
   localparam logic [3:0] LG_XNOR = 4'h5;
   localparam logic [3:0] LG_BYOR = 4'h6;

   function automatic grp_e grp_of(input logic [OPC_W-1:0] op);
      return grp_e'(op[OPC_W-1:OPC_W-3]);
   endfunction

endpackage

// File: rtl/xalu_cmp.sv
module xalu_cmp #(
   parameter int XLEN = 64
) (
   input  logic [XLEN-1:0] a_i,
   input  logic [XLEN-1:0] b_i,
   output logic            eq_o,
   output logic            lt_o,
   output logic            ltu_o
);

   assign eq_o  = (a_i == b_i);
   assign ltu_o = (a_i < b_i);
   assign lt_o  = ($signed(a_i) < $signed(b_i));

endmodule

// File: rtl/xalu_shift.sv
module xalu_shift
   import xalu_pkg::*;
#(
   parameter int XLEN = 64,
   parameter int WLEN = 32
) (
   input  logic [OPC_W-1:0]        op_i,
   input  logic [XLEN-1:0]         a_i,
   input  logic [$clog2(XLEN)-1:0] amt_i,
   output logic [XLEN-1:0]         res_o
);

   localparam int SHW  = $clog2(XLEN);
   localparam int WSHW = $clog2(WLEN);
   localparam int PADW = XLEN - WLEN;

   logic [SHW-1:0]  sh;
   logic [WSHW-1:0] wsh;
   logic [SHW:0]    sh_inv;
   logic [WSHW:0]   wsh_inv;
   logic [XLEN-1:0] bitmask;
   logic [XLEN-1:0] a_zw;
   logic [WLEN-1:0] aw;
   logic [XLEN-1:0] r_sll, r_srl, r_sra, r_rol, r_ror, r_sllz;
   logic [WLEN-1:0] w_sll, w_srl, w_sra, w_rol, w_ror;

   assign sh      = amt_i;
   assign wsh     = amt_i[WSHW-1:0];
   assign sh_inv  = (SHW+1)'(XLEN) - {1'b0, sh};
   assign wsh_inv = (WSHW+1)'(WLEN) - {1'b0, wsh};
   assign bitmask = XLEN'(1) << sh;
   assign aw      = a_i[WLEN-1:0];
   assign a_zw    = {{PADW{1'b0}}, aw};

   assign r_sll  = a_i << sh;
   assign r_srl  = a_i >> sh;
   assign r_sra  = $signed(a_i) >>> sh;
   assign r_rol  = (a_i << sh) | (a_i >> sh_inv);
   assign r_ror  = (a_i >> sh) | (a_i << sh_inv);
   assign r_sllz = a_zw << sh;

   assign w_sll = aw << wsh;
   assign w_srl = aw >> wsh;
   assign w_sra = $signed(aw) >>> wsh;
   assign w_rol = (aw << wsh) | (aw >> wsh_inv);
   assign w_ror = (aw >> wsh) | (aw << wsh_inv);

   function automatic logic [XLEN-1:0] sext_w(input logic [WLEN-1:0] w);
      return {{PADW{w[WLEN-1]}}, w};
   endfunction

   always_comb begin
      res_o = '0;
      case (op_i)
         OP_SLLZW: res_o = r_sllz;
         OP_SLL:   res_o = r_sll;
         OP_BCLR:  res_o = a_i & ~bitmask;
         OP_BSET:  res_o = a_i | bitmask;
         OP_BTOG:  res_o = a_i ^ bitmask;
         OP_SRL:   res_o = r_srl;
         OP_BGET:  res_o = {{(XLEN-1){1'b0}}, a_i[sh]};
         OP_SRA:   res_o = r_sra;
         OP_ROL:   res_o = r_rol;
         OP_ROR:   res_o = r_ror;
         OP_WSLL:  res_o = sext_w(w_sll);
         OP_WSRL:  res_o = sext_w(w_srl);
         OP_WSRA:  res_o = sext_w(w_sra);
         OP_WROL:  res_o = sext_w(w_rol);
         OP_WROR:  res_o = sext_w(w_ror);
         default:  res_o = '0;
      endcase
   end

endmodule

// File: rtl/xalu_arith.sv
module xalu_arith
   import xalu_pkg::*;
#(
   parameter int XLEN = 64,
   parameter int WLEN = 32,
   parameter int HLEN = 16
) (
   input  logic [OPC_W-1:0] op_i,
   input  logic [XLEN-1:0]  a_i,
   input  logic [XLEN-1:0]  b_i,
   input  logic             lt_i,
   input  logic             ltu_i,
   output logic [XLEN-1:0]  res_o
);

   localparam int PADW    = XLEN - WLEN;
   localparam int BLEN    = 8;
   localparam int SR_BASE = WLEN - 3;
   localparam int NSR     = 4;
   localparam int NSC     = 4;

   logic [XLEN-1:0] sum, diff, odd_sum, zw_sum, a_zw;
   logic [XLEN-1:0] sr_sum   [NSR];
   logic [XLEN-1:0] sc_sum   [NSC];
   logic [XLEN-1:0] sc_zsum  [NSC];

   assign a_zw    = {{PADW{1'b0}}, a_i[WLEN-1:0]};
   assign sum     = a_i + b_i;
   assign diff    = a_i - b_i;
   assign odd_sum = {{(XLEN-1){1'b0}}, a_i[0]} + b_i;
   assign zw_sum  = a_zw + b_i;

   for (genvar k = 0; k < NSR; k++) begin : g_sradd
      assign sr_sum[k] = (a_i >> (SR_BASE + k)) + b_i;
   end

   for (genvar s = 0; s < NSC; s++) begin : g_scadd
      assign sc_sum[s]  = (a_i << (s + 1)) + b_i;
      assign sc_zsum[s] = (a_zw << (s + 1)) + b_i;
   end

   function automatic logic [XLEN-1:0] sext_w(input logic [WLEN-1:0] w);
      return {{PADW{w[WLEN-1]}}, w};
   endfunction

   always_comb begin
      res_o = '0;
      case (op_i)
         OP_WADD:  res_o = sext_w(sum[WLEN-1:0]);
         OP_WODD:  res_o = sext_w(odd_sum[WLEN-1:0]);
         OP_WSUB:  res_o = sext_w(diff[WLEN-1:0]);
         OP_WBIT:  res_o = {{(XLEN-1){1'b0}}, sum[0]};
         OP_WBYTE: res_o = {{(XLEN-BLEN){1'b0}}, sum[BLEN-1:0]};
         OP_WZH:   res_o = {{(XLEN-HLEN){1'b0}}, sum[HLEN-1:0]};
         OP_WSH:   res_o = {{(XLEN-HLEN){sum[HLEN-1]}}, sum[HLEN-1:0]};
         OP_ADDZW: res_o = zw_sum;
         OP_ADD:   res_o = sum;
         OP_ODD:   res_o = odd_sum;
         OP_SR0:   res_o = sr_sum[0];
         OP_SR1:   res_o = sr_sum[1];
         OP_SR2:   res_o = sr_sum[2];
         OP_SR3:   res_o = sr_sum[3];
         OP_SC1Z:  res_o = sc_zsum[0];
         OP_SC1:   res_o = sc_sum[0];
         OP_SC2Z:  res_o = sc_zsum[1];
         OP_SC2:   res_o = sc_sum[1];
         OP_SC3Z:  res_o = sc_zsum[2];
         OP_SC3:   res_o = sc_sum[2];
         OP_SC4:   res_o = sc_sum[3];
         OP_SUB:   res_o = diff;
         OP_LTU:   res_o = {{(XLEN-1){1'b0}}, ltu_i};
         OP_LT:    res_o = {{(XLEN-1){1'b0}}, lt_i};
         OP_MAXU:  res_o = ltu_i ? b_i : a_i;
         OP_MINU:  res_o = ltu_i ? a_i : b_i;
         OP_MAX:   res_o = lt_i  ? b_i : a_i;
         OP_MIN:   res_o = lt_i  ? a_i : b_i;
         default:  res_o = '0;
      endcase
   end

endmodule

// File: rtl/xalu_logic.sv
module xalu_logic
   import xalu_pkg::*;
#(
   parameter int XLEN = 64,
   parameter int HLEN = 16
) (
   input  logic [OPC_W-1:0] op_i,
   input  logic [XLEN-1:0]  a_i,
   input  logic [XLEN-1:0]  b_i,
   output logic [XLEN-1:0]  res_o
);

   localparam int NBYTE = XLEN / 8;

   grp_e            grp;
   logic [3:0]      lcode;
   logic [XLEN-1:0] byte_or;
   logic [XLEN-1:0] lres;

   assign grp   = grp_of(op_i);
   // fused forms reuse the plain logic code with its low bit cleared
   assign lcode = (grp == GRP_FUSED) ? {op_i[3:1], 1'b0} : op_i[3:0];

   for (genvar n = 0; n < NBYTE; n++) begin : g_byor
      assign byte_or[8*n +: 8] = {8{|a_i[8*n +: 8]}};
   end

   always_comb begin
      case (lcode)
         LG_AND:  lres = a_i & b_i;
         LG_ANDN: lres = a_i & ~b_i;
         LG_OR:   lres = a_i | b_i;
         LG_ORN:  lres = a_i | ~b_i;
         LG_XOR:  lres = a_i ^ b_i;
         LG_XNOR: lres = ~(a_i ^ b_i);
         LG_BYOR: lres = byte_or;
         default: lres = '0;
      endcase
   end

   always_comb begin
      res_o = '0;
      if (grp == GRP_LOGIC) begin
         res_o = lres;
      end else if (grp == GRP_FUSED) begin
         if (op_i[0]) res_o = {{(XLEN-HLEN){1'b0}}, lres[HLEN-1:0]};
         else         res_o = {{(XLEN-1){1'b0}}, lres[0]};
      end
   end

endmodule

// File: rtl/xalu.sv
module xalu
   import xalu_pkg::*;
#(
   parameter int XLEN = 64,
   parameter int WLEN = 32,
   parameter int HLEN = 16
) (
   input  logic [OPC_W-1:0] opc_i,
   input  logic [XLEN-1:0]  src1_i,
   input  logic [XLEN-1:0]  src2_i,
   output logic [XLEN-1:0]  result_o,
   output logic             taken_o
);

   localparam int SHW = $clog2(XLEN);

   if (XLEN != 2 * WLEN) begin : g_bad_xlen
      $error("xalu: XLEN must be twice WLEN");
   end
   if (WLEN < 2 * HLEN) begin : g_bad_wlen
      $error("xalu: WLEN must be at least twice HLEN");
   end
   if ((1 << SHW) != XLEN) begin : g_bad_pow2
      $error("xalu: XLEN must be a power of two");
   end
   if (HLEN < 8) begin : g_bad_hlen
      $error("xalu: HLEN must hold at least a byte");
   end

   logic            c_eq, c_lt, c_ltu;
   logic [XLEN-1:0] r_shift, r_arith, r_logic;
   cmp_e            bkind;
   logic            bcond;

   xalu_cmp #(.XLEN(XLEN)) i_cmp (
      .a_i   (src1_i),
      .b_i   (src2_i),
      .eq_o  (c_eq),
      .lt_o  (c_lt),
      .ltu_o (c_ltu)
   );

   xalu_shift #(.XLEN(XLEN), .WLEN(WLEN)) i_shift (
      .op_i  (opc_i),
      .a_i   (src1_i),
      .amt_i (src2_i[SHW-1:0]),
      .res_o (r_shift)
   );

   xalu_arith #(.XLEN(XLEN), .WLEN(WLEN), .HLEN(HLEN)) i_arith (
      .op_i  (opc_i),
      .a_i   (src1_i),
      .b_i   (src2_i),
      .lt_i  (c_lt),
      .ltu_i (c_ltu),
      .res_o (r_arith)
   );

   xalu_logic #(.XLEN(XLEN), .HLEN(HLEN)) i_logic (
      .op_i  (opc_i),
      .a_i   (src1_i),
      .b_i   (src2_i),
      .res_o (r_logic)
   );

   // each unit drives zero for codes it does not own
   assign result_o = r_shift | r_arith | r_logic;

   assign bkind = cmp_e'(opc_i[3:2]);

   always_comb begin
      case (bkind)
         CMP_EQ:  bcond = c_eq;
         CMP_LT:  bcond = c_lt;
         CMP_LTU: bcond = c_ltu;
         default: bcond = 1'b0;
      endcase
   end

   assign taken_o = (grp_of(opc_i) == GRP_BRANCH) && (bkind != CMP_NONE)
                    && (bcond ^ opc_i[1]);

endmodule

// File: rtl/xalu_chk.sv
module xalu_chk
   import xalu_pkg::*;
#(
   parameter int XLEN = 64
) (
   input logic [OPC_W-1:0] opc_i,
   input logic [XLEN-1:0]  src1_i,
   input logic [XLEN-1:0]  src2_i,
   input logic [XLEN-1:0]  result_o,
   input logic             taken_o
);

   localparam int HALF = XLEN / 2;

   logic is_wsext;
   assign is_wsext = (opc_i == OP_WADD) || (opc_i == OP_WODD) || (opc_i == OP_WSUB)
                  || (opc_i == OP_WSLL) || (opc_i == OP_WSRL) || (opc_i == OP_WSRA)
                  || (opc_i == OP_WROL) || (opc_i == OP_WROR);

   always_comb begin
      if (opc_i[6:4] != 3'b111)
         AST_TAKEN_BRANCH_ONLY: assert (!taken_o) else $error("taken outside branch group"); // R1
      if (opc_i[6:4] == 3'b101)
         AST_SPARE_GROUP_ZERO: assert (result_o == '0) else $error("spare group nonzero"); // R1
      if (opc_i == OP_BGET)
         AST_BIT_GET_ONE_BIT: assert (result_o[XLEN-1:1] == '0) else $error("bit extract wide"); // R3
      if (is_wsext)
         AST_WORD_SIGN_EXT: assert (result_o[XLEN-1:HALF] == {HALF{result_o[HALF-1]}}) else $error("word not sign-extended"); // R4
      if ((opc_i == OP_LT) || (opc_i == OP_LTU))
         AST_SET_LESS_BOOL: assert (result_o[XLEN-1:1] == '0) else $error("compare not boolean"); // R8
      if ((opc_i[6:4] == 3'b110) && !opc_i[0])
         AST_FUSED_LSB_ONLY: assert (result_o[XLEN-1:1] == '0) else $error("fused lsb wide"); // R10
      if ((opc_i[6:4] == 3'b110) && opc_i[0])
         AST_FUSED_HALF_ZEXT: assert (result_o[XLEN-1:16] == '0) else $error("fused half wide"); // R10
      if (opc_i[6:4] == 3'b111)
         AST_BRANCH_RESULT_ZERO: assert (result_o == '0) else $error("branch result nonzero"); // R11
      if (opc_i[6:1] == 6'b111000)
         AST_BRANCH_EQ: assert (taken_o == (src1_i == src2_i)) else $error("beq wrong"); // R11
   end

endmodule

bind xalu xalu_chk #(.XLEN(XLEN)) i_chk (
   .opc_i    (opc_i),
   .src1_i   (src1_i),
   .src2_i   (src2_i),
   .result_o (result_o),
   .taken_o  (taken_o)
);

// File: tb/test_xalu.sv
module test_xalu;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   typedef struct {
      logic [6:0]  op;
      logic [63:0] a;
      logic [63:0] b;
      logic [63:0] res;
      logic        tk;
      string       tag;
   } item_t;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [6:0]  opc  = '0;
   logic [63:0] src1 = '0;
   logic [63:0] src2 = '0;
   logic [63:0] result;
   logic        taken;

   int    n_tests = 0;
   int    n_fail  = 0;
   bit    done    = 1'b0;
   item_t sb_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   xalu i_xalu (
      .opc_i    (opc),
      .src1_i   (src1),
      .src2_i   (src2),
      .result_o (result),
      .taken_o  (taken)
   );

   function automatic logic [63:0] sx32(input logic [31:0] w);
      return {{32{w[31]}}, w};
   endfunction

   function automatic logic [63:0] lg_ref(input logic [3:0] c, input logic [63:0] a, input logic [63:0] b);
      logic [63:0] r;
      r = '0;
      case (c)
         4'h0: r = a & b;
         4'h1: r = a & ~b;
         4'h2: r = a | b;
         4'h3: r = a | ~b;
         4'h4: r = a ^ b;
         4'h5: r = ~(a ^ b);
         4'h6: for (int i = 0; i < 8; i++) r[8*i +: 8] = (a[8*i +: 8] != 8'h00) ? 8'hFF : 8'h00;
         default: r = '0;
      endcase
      return r;
   endfunction

   function automatic void ref_alu(input logic [6:0] op, input logic [63:0] a, input logic [63:0] b,
                                   output logic [63:0] r, output logic t, output string tag);
      logic [5:0]   s;
      logic [4:0]   ws;
      logic [63:0]  sm, df, zw, ww;
      logic [127:0] dd;
      logic [31:0]  w;
      logic         slt, sltu, cnd;
      s    = b[5:0];
      ws   = b[4:0];
      sm   = a + b;
      df   = a - b;
      zw   = {32'h0, a[31:0]};
      sltu = (a < b);
      slt  = (a[63] != b[63]) ? a[63] : (a < b);
      r = '0; t = 1'b0; tag = "R1";
      case (op)
         7'h00: begin r = zw << s; tag = "R2"; end
         7'h01: begin r = a << s; tag = "R2"; end
         7'h05: begin r = a >> s; tag = "R2"; end
         7'h07: begin r = 64'($signed(a) >>> s); tag = "R2"; end
         7'h09: begin dd = {a, a} << s; r = dd[127:64]; tag = "R2"; end
         7'h0B: begin dd = {a, a} >> s; r = dd[63:0]; tag = "R2"; end
         7'h02: begin r = a; r[s] = 1'b0; tag = "R3"; end
         7'h03: begin r = a; r[s] = 1'b1; tag = "R3"; end
         7'h04: begin r = a; r[s] = ~a[s]; tag = "R3"; end
         7'h06: begin r = {63'h0, a[s]}; tag = "R3"; end
         7'h10: begin r = sx32(sm[31:0]); tag = "R4"; end
         7'h12: begin r = sx32(df[31:0]); tag = "R4"; end
         7'h18: begin w = a[31:0] << ws; r = sx32(w); tag = "R4"; end
         7'h19: begin w = a[31:0] >> ws; r = sx32(w); tag = "R4"; end
         7'h1A: begin w = 32'($signed(a[31:0]) >>> ws); r = sx32(w); tag = "R4"; end
         7'h1C: begin ww = {a[31:0], a[31:0]} << ws; r = sx32(ww[63:32]); tag = "R4"; end
         7'h1D: begin ww = {a[31:0], a[31:0]} >> ws; r = sx32(ww[31:0]); tag = "R4"; end
         7'h11: begin ww = b + {63'h0, a[0]}; r = sx32(ww[31:0]); tag = "R5"; end
         7'h14: begin r = {63'h0, sm[0]}; tag = "R5"; end
         7'h15: begin r = {56'h0, sm[7:0]}; tag = "R5"; end
         7'h16: begin r = {48'h0, sm[15:0]}; tag = "R5"; end
         7'h17: begin r = {{48{sm[15]}}, sm[15:0]}; tag = "R5"; end
         7'h20: begin r = zw + b; tag = "R6"; end
         7'h21: begin r = sm; tag = "R6"; end
         7'h22: begin r = b + {63'h0, a[0]}; tag = "R6"; end
         7'h24: begin r = (a >> 29) + b; tag = "R6"; end
         7'h25: begin r = (a >> 30) + b; tag = "R6"; end
         7'h26: begin r = (a >> 31) + b; tag = "R6"; end
         7'h27: begin r = {32'h0, a[63:32]} + b; tag = "R6"; end
         7'h28: begin r = (zw << 1) + b; tag = "R7"; end
         7'h29: begin r = (a << 1) + b; tag = "R7"; end
         7'h2A: begin r = (zw << 2) + b; tag = "R7"; end
         7'h2B: begin r = (a << 2) + b; tag = "R7"; end
         7'h2C: begin r = (zw << 3) + b; tag = "R7"; end
         7'h2D: begin r = (a << 3) + b; tag = "R7"; end
         7'h2F: begin r = (a << 4) + b; tag = "R7"; end
         7'h30: begin r = df; tag = "R8"; end
         7'h31: begin r = {63'h0, sltu}; tag = "R8"; end
         7'h32: begin r = {63'h0, slt}; tag = "R8"; end
         7'h34: begin r = sltu ? b : a; tag = "R8"; end
         7'h35: begin r = sltu ? a : b; tag = "R8"; end
         7'h36: begin r = slt ? b : a; tag = "R8"; end
         7'h37: begin r = slt ? a : b; tag = "R8"; end
         default: begin
            if (op[6:3] == 4'b1000 && op[2:0] != 3'b111) begin
               r = lg_ref(op[3:0], a, b); tag = "R9";
            end else if (op[6:3] == 4'b1100) begin
               ww = lg_ref({op[3:1], 1'b0}, a, b);
               r = op[0] ? {48'h0, ww[15:0]} : {63'h0, ww[0]};
               tag = "R10";
            end else if (op[6:4] == 3'b111) begin
               tag = "R11";
               case (op[3:2])
                  2'b00: cnd = (a == b);
                  2'b10: cnd = slt;
                  2'b11: cnd = sltu;
                  default: cnd = 1'b0;
               endcase
               t = (op[3:2] == 2'b01) ? 1'b0 : (cnd ^ op[1]);
            end
         end
      endcase
   endfunction

   task automatic drive(input logic [6:0] op, input logic [63:0] a, input logic [63:0] b);
      item_t it;
      @(posedge clk);
      opc  = op;
      src1 = a;
      src2 = b;
      it.op = op; it.a = a; it.b = b;
      ref_alu(op, a, b, it.res, it.tk, it.tag);
      sb_q.push_back(it);
   endtask

   // monitor: compares one queued item per falling edge
   initial begin
      item_t it;
      forever begin
         @(negedge clk);
         if (sb_q.size() > 0) begin
            it = sb_q.pop_front();
            n_tests++;
            if (result !== it.res || taken !== it.tk) begin
               n_fail++;
               $display("FAIL %s op=%h a=%h b=%h: result %h taken %b, expected %h taken %b",
                        it.tag, it.op, it.a, it.b, result, taken, it.res, it.tk);
            end
         end
      end
   end

   initial begin
      logic [63:0] corner [8];
      corner[0] = 64'h0;
      corner[1] = 64'hFFFF_FFFF_FFFF_FFFF;
      corner[2] = 64'h8000_0000_0000_0000;
      corner[3] = 64'h7FFF_FFFF_FFFF_FFFF;
      corner[4] = 64'h0000_0000_8000_0000;
      corner[5] = 64'd31;
      corner[6] = 64'd32;
      corner[7] = 64'd63;

      // idle state with all-zero inputs (R1)
      repeat (2) @(posedge clk);
      #1;
      n_tests++;
      if (result !== 64'h0 || taken !== 1'b0) begin
         n_fail++;
         $display("FAIL R1 idle: result %h taken %b, expected 0 taken 0", result, taken);
      end
      rst = 1'b0;

      // directed: shift amount bits above [5:0] are ignored (R2)
      drive(7'h01, 64'h1, 64'hFFFF_FFFF_FFFF_FF01);
      // directed: rotate by zero returns the operand (R2)
      drive(7'h09, 64'hDEAD_BEEF_0123_4567, 64'h40);
      // directed: word shift uses only src2[4:0] (R4)
      drive(7'h18, 64'h1, 64'h21);
      // directed: branch bit 0 ignored, test 01 never taken (R11)
      drive(7'h71, 64'h5, 64'h5);
      drive(7'h76, 64'h5, 64'h7);
      // directed: unassigned codes (R1)
      drive(7'h2E, 64'h1234, 64'h5678);
      drive(7'h50, 64'hFFFF, 64'hFFFF);

      for (int op = 0; op < 128; op++)
         for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++)
               drive(7'(op), corner[i], corner[j]);

      for (int op = 0; op < 128; op++)
         for (int k = 0; k < 16; k++)
            drive(7'(op), {$urandom(), $urandom()}, {$urandom(), $urandom()});

      repeat (3) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule